// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a word-wide general-purpose I/O port controlled through a simple single-cycle register bus. Software sets a per-bit direction mask. Pins marked as outputs take their drive level from a level register, which is changed only through set and clear registers. Pins marked as inputs are synchronised through a flop chain and copied into the same level register on every clock. An edge detector watches the synchronised pins and latches per-bit status for enabled rising or falling changes. Software clears that status by writing ones, and its OR forms a single interrupt line.

A set or clear write is accepted or refused as a whole. It is accepted only if the written mask shares at least one bit with the output-direction mask. A refused write changes nothing and pulses an error flag. A write to an offset with no register behind it also pulses the flag.

Reads return data one cycle after the access. Only three registers can be read back: level, direction and a spare general-purpose word. Every other offset reads as zero.

Top module: `gpio_port`

## Requirements
- R1: Byte offsets are fixed: level 0x00, direction 0x04, set 0x08, clear 0x0C, rise-enable 0x10, fall-enable 0x14, edge status 0x18, spare 0x20. Every access is a full word. A read of level, direction or spare returns that register on `busRdata` in the cycle after the read is sampled.
- R2: A read of any other offset returns zero. This includes set, clear, both enables, edge status, unmapped offsets and offsets whose two low bits are not 00.
- R3: A write to direction replaces the whole register. From the next cycle `pinOe` equals the written value (1 = output).
- R4: A write to the spare register replaces it, and a later read returns the new value.
- R5: A set write whose data has at least one bit in common with direction is accepted. Every written bit that is an output becomes 1 on `pinOut`.
- R6: A clear write under the same overlap rule forces every written bit that is an output to 0 on `pinOut`.
- R7: A set or clear write with no overlap leaves `pinOut` unchanged. `accessErr` is high for exactly the one cycle after the write.
- R8: After reset, level, direction, spare and edge status are zero, and `pinOut`, `pinOe`, `irqOut` and `accessErr` are 0.
- R9: Level bits for inputs follow `pinIn` through a two-flop synchroniser. Level bits for outputs keep their set/clear value whatever `pinIn` does.
- R10: A status bit is set by a 0-to-1 change of its synchronised pin when its rise-enable bit is 1. It is also set by a 1-to-0 change when its fall-enable bit is 1. A change whose enable is 0 sets nothing.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it as it is. If an enabled edge and the clear land in the same cycle, the bit stays set.
- R12: `irqOut` is the OR of all edge-status bits.
- R13: A write to an undefined or misaligned offset changes no register and pulses `accessErr` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, registered |
| accessErr | output | 1 | One-cycle pulse after a refused or undefined write |
| pinIn | input | DATA_W | Raw pin levels from the pads |
| pinOut | output | DATA_W | Pin drive values |
| pinOe | output | DATA_W | Per-bit output enable |
| irqOut | output | 1 | Combined edge interrupt |

## Verification
The hardest case to reach is an enabled edge arriving in the same cycle as a write-one-to-clear of its own status bit. The two meet only if the clear write is sampled on the exact edge where the synchronised pin first differs from its previous value. The stimulus changes the pin on a falling clock edge, lets one more falling edge pass, then issues the clear. The write is then sampled on the third rising edge, which is the edge where the change leaves the second synchroniser flop. Whether the status bit survives is then visible on `irqOut`.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam logic [7:0] OFF_LEVEL = 8'h00;
  localparam logic [7:0] OFF_DIR   = 8'h04;
  localparam logic [7:0] OFF_SET   = 8'h08;
  localparam logic [7:0] OFF_CLR   = 8'h0C;
  localparam logic [7:0] OFF_RISE  = 8'h10;
  localparam logic [7:0] OFF_FALL  = 8'h14;
  localparam logic [7:0] OFF_STAT  = 8'h18;
  localparam logic [7:0] OFF_SPARE = 8'h20;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_LEVEL = 2'd1,
    RD_DIR   = 2'd2,
    RD_SPARE = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrSpare;
    logic   wrSet;
    logic   wrClr;
    logic   wrRise;
    logic   wrFall;
    logic   wrStat;
    logic   rdEn;
    rdSrc_e rdSrc;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rawIn,
  output logic [DATA_W-1:0] syncOut
);

  logic [STAGES-1:0][DATA_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= rawIn;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] outMask,
  output gpioStrobe_t       strobe,
  output logic              errPulse
);

  logic aligned;
  logic hitLevel, hitDir, hitSet, hitClr, hitRise, hitFall, hitStat, hitSpare;
  logic hitAny, wrAcc, rdAcc, overlap, badWrite;

  always_comb begin
    aligned  = (busAddr[1:0] == 2'b00);
    hitLevel = aligned && (busAddr == ADDR_W'(OFF_LEVEL));
    hitDir   = aligned && (busAddr == ADDR_W'(OFF_DIR));
    hitSet   = aligned && (busAddr == ADDR_W'(OFF_SET));
    hitClr   = aligned && (busAddr == ADDR_W'(OFF_CLR));
    hitRise  = aligned && (busAddr == ADDR_W'(OFF_RISE));
    hitFall  = aligned && (busAddr == ADDR_W'(OFF_FALL));
    hitStat  = aligned && (busAddr == ADDR_W'(OFF_STAT));
    hitSpare = aligned && (busAddr == ADDR_W'(OFF_SPARE));
    hitAny   = hitLevel | hitDir | hitSet | hitClr | hitRise | hitFall | hitStat | hitSpare;
    wrAcc    = busSel && busWr;
    rdAcc    = busSel && !busWr;
    overlap  = |(busWdata & outMask);
  end

  always_comb begin
    strobe         = '0;
    strobe.rdSrc   = RD_ZERO;
    badWrite       = 1'b0;
    if (rdAcc) begin
      strobe.rdEn = 1'b1;
      if (hitLevel)      strobe.rdSrc = RD_LEVEL;
      else if (hitDir)   strobe.rdSrc = RD_DIR;
      else if (hitSpare) strobe.rdSrc = RD_SPARE;
      else               strobe.rdSrc = RD_ZERO;
    end
    if (wrAcc) begin
      strobe.wrDir   = hitDir;
      strobe.wrSpare = hitSpare;
      strobe.wrSet   = hitSet && overlap;
      strobe.wrClr   = hitClr && overlap;
      strobe.wrRise  = hitRise;
      strobe.wrFall  = hitFall;
      strobe.wrStat  = hitStat;
      badWrite       = !hitAny || hitLevel || ((hitSet || hitClr) && !overlap);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= badWrite;
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] pinSync,
  output logic [DATA_W-1:0] dirReg,
  output logic [DATA_W-1:0] levelReg,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqAny
);

  logic [DATA_W-1:0] spareReg, riseEn, fallEn, statusReg, pinPrev;
  logic [DATA_W-1:0] levelNext, edgeHits, clrMask, statusNext, outBits;

  always_comb begin
    outBits = levelReg & dirReg;
    if (strobe.wrSet) outBits = outBits | (busWdata & dirReg);
    if (strobe.wrClr) outBits = outBits & ~(busWdata & dirReg);
    levelNext = outBits | (pinSync & ~dirReg);
  end

  always_comb begin
    edgeHits   = (pinSync & ~pinPrev & riseEn) | (~pinSync & pinPrev & fallEn);
    clrMask    = strobe.wrStat ? busWdata : '0;
    statusNext = (statusReg & ~clrMask) | edgeHits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg    <= '0;
      spareReg  <= '0;
      riseEn    <= '0;
      fallEn    <= '0;
      levelReg  <= '0;
      statusReg <= '0;
      pinPrev   <= '0;
    end else begin
      if (strobe.wrDir)   dirReg   <= busWdata;
      if (strobe.wrSpare) spareReg <= busWdata;
      if (strobe.wrRise)  riseEn   <= busWdata;
      if (strobe.wrFall)  fallEn   <= busWdata;
      levelReg  <= levelNext;
      statusReg <= statusNext;
      pinPrev   <= pinSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strobe.rdEn) begin
      case (strobe.rdSrc)
        RD_LEVEL: busRdata <= levelReg;
        RD_DIR:   busRdata <= dirReg;
        RD_SPARE: busRdata <= spareReg;
        default:  busRdata <= '0;
      endcase
    end
  end

  assign irqAny = |statusReg;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              accessErr,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic              irqOut
);

  gpioStrobe_t       strobe;
  logic [DATA_W-1:0] pinSync, dirReg, levelReg;

  gpio_port_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .rawIn(pinIn), .syncOut(pinSync)
  );

  gpio_port_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .outMask(dirReg), .strobe(strobe), .errPulse(accessErr)
  );

  gpio_port_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata), .pinSync(pinSync),
    .dirReg(dirReg), .levelReg(levelReg), .busRdata(busRdata), .irqAny(irqOut)
  );

  assign pinOe  = dirReg;
  assign pinOut = levelReg & dirReg;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              accessErr,
  input logic [DATA_W-1:0] pinOut,
  input logic [DATA_W-1:0] pinOe,
  input logic              irqOut
);

  logic wrDirC, wrSetC, wrClrC, wrStatC, rdReadable, ovl;
  assign wrDirC     = busSel && busWr && (busAddr == ADDR_W'(OFF_DIR));
  assign wrSetC     = busSel && busWr && (busAddr == ADDR_W'(OFF_SET));
  assign wrClrC     = busSel && busWr && (busAddr == ADDR_W'(OFF_CLR));
  assign wrStatC    = busSel && busWr && (busAddr == ADDR_W'(OFF_STAT));
  assign rdReadable = (busAddr == ADDR_W'(OFF_LEVEL)) || (busAddr == ADDR_W'(OFF_DIR)) ||
                      (busAddr == ADDR_W'(OFF_SPARE));
  assign ovl        = |(busWdata & pinOe);

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rstN)
    wrDirC |=> (pinOe == $past(busWdata))); // R3

  AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
    (wrSetC && ovl) |=> ((pinOut & $past(busWdata & pinOe)) == $past(busWdata & pinOe))); // R5

  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
    (wrClrC && ovl) |=> ((pinOut & $past(busWdata & pinOe)) == '0)); // R6

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ((wrSetC || wrClrC) && !ovl) |=> ($stable(pinOut) && accessErr)); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> $past(busSel && busWr)); // R13

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(wrStatC)); // R11

  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && !rdReadable) |=> (busRdata == '0)); // R2

endmodule

bind gpio_port gpio_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;

  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          accessErr;
  logic [DW-1:0] pinIn = '0;
  logic [DW-1:0] pinOut;
  logic [DW-1:0] pinOe;
  logic          irqOut;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } rdItem_t;
  rdItem_t expQ[$];
  logic    readSeen = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .accessErr(accessErr), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one cycle after each sampled read
  always @(posedge clk) readSeen <= busSel && !busWr;
  always @(negedge clk) begin
    if (readSeen) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected read data actual=%h expected=none", busRdata);
      end else begin
        rdItem_t it;
        it = expQ.pop_front();
        chk(it.tag, busRdata, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic err);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    err = accessErr;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    rdItem_t it;
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic e;
    idle(4);
    rstN = 1'b1;
    idle(1);
    // R8 reset state
    chk("R8 pinOut", pinOut, '0);
    chk("R8 pinOe", pinOe, '0);
    chk("R8 irq", {31'b0, irqOut}, 0);
    chk("R8 err", {31'b0, accessErr}, 0);
    busRead(6'h00, 32'h0, "R8 level");
    busRead(6'h04, 32'h0, "R8 dir");
    busRead(6'h20, 32'h0, "R8 spare");

    // R4 spare register
    busWrite(6'h20, 32'hA5A5_1234, e);
    busRead(6'h20, 32'hA5A5_1234, "R4 spare first");
    busWrite(6'h20, 32'h0F0F_0000, e);
    busRead(6'h20, 32'h0F0F_0000, "R4 spare replace");

    // R3 direction
    busWrite(6'h04, 32'h0000_00FF, e);
    chk("R3 pinOe", pinOe, 32'h0000_00FF);
    busRead(6'h04, 32'h0000_00FF, "R1 dir readback");

    // R5 accepted set
    busWrite(6'h08, 32'h0000_0F03, e);
    chk("R5 err", {31'b0, e}, 0);
    chk("R5 pinOut", pinOut, 32'h0000_0003);
    busRead(6'h00, 32'h0000_0003, "R1 level readback");

    // R7 refused set
    busWrite(6'h08, 32'h0000_FF00, e);
    chk("R7 set err pulse", {31'b0, e}, 1);
    chk("R7 set pinOut held", pinOut, 32'h0000_0003);
    idle(1);
    chk("R7 err one cycle", {31'b0, accessErr}, 0);

    // R6 clear
    busWrite(6'h0C, 32'h0000_0001, e);
    chk("R6 err", {31'b0, e}, 0);
    chk("R6 pinOut", pinOut, 32'h0000_0002);
    busWrite(6'h0C, 32'h00F0_0000, e);
    chk("R7 clr err pulse", {31'b0, e}, 1);
    chk("R7 clr pinOut held", pinOut, 32'h0000_0002);

    // R9 inputs synchronised into level, outputs unaffected
    pinIn = 32'h5A00_0FF0;
    idle(4);
    busRead(6'h00, 32'h5A00_0F02, "R9 level mix");
    chk("R9 pinOut outputs hold", pinOut, 32'h0000_0002);

    // R13 undefined and misaligned writes
    busWrite(6'h24, 32'hFFFF_FFFF, e);
    chk("R13 undefined err", {31'b0, e}, 1);
    busWrite(6'h05, 32'hFFFF_FFFF, e);
    chk("R13 misaligned err", {31'b0, e}, 1);
    busRead(6'h04, 32'h0000_00FF, "R13 dir untouched");
    busRead(6'h20, 32'h0F0F_0000, "R13 spare untouched");
    chk("R13 pinOut untouched", pinOut, 32'h0000_0002);

    // R2 reads of non-readable offsets
    pinIn = '0;
    idle(4);
    busWrite(6'h10, 32'h0001_0000, e);
    busWrite(6'h14, 32'h0002_0000, e);
    busRead(6'h08, 32'h0, "R2 set reads zero");
    busRead(6'h0C, 32'h0, "R2 clear reads zero");
    busRead(6'h10, 32'h0, "R2 rise enable reads zero");
    busRead(6'h14, 32'h0, "R2 fall enable reads zero");
    busRead(6'h18, 32'h0, "R2 status reads zero");
    busRead(6'h24, 32'h0, "R2 unmapped reads zero");
    busRead(6'h02, 32'h0, "R2 misaligned reads zero");

    // R10 edge detection
    chk("R10 irq idle", {31'b0, irqOut}, 0);
    pinIn[16] = 1'b1;
    idle(4);
    chk("R10 rise flagged", {31'b0, irqOut}, 1);
    busWrite(6'h18, 32'h0001_0000, e);
    chk("R11 w1c clears", {31'b0, irqOut}, 0);
    pinIn[17] = 1'b1;
    idle(4);
    chk("R10 rise not enabled", {31'b0, irqOut}, 0);
    pinIn[16] = 1'b0;
    idle(4);
    chk("R10 fall not enabled", {31'b0, irqOut}, 0);
    pinIn[17] = 1'b0;
    idle(4);
    chk("R10 fall flagged", {31'b0, irqOut}, 1);

    // R12 combined line with two status bits, R11 per-bit clear
    pinIn[16] = 1'b1;
    idle(4);
    busWrite(6'h18, 32'h0000_0000, e);
    chk("R11 write zero keeps", {31'b0, irqOut}, 1);
    busWrite(6'h18, 32'h0001_0000, e);
    chk("R12 one bit left keeps irq", {31'b0, irqOut}, 1);
    busWrite(6'h18, 32'h0002_0000, e);
    chk("R12 all clear drops irq", {31'b0, irqOut}, 0);

    // R11 edge and clear in the same cycle: edge wins
    pinIn[17] = 1'b1;
    idle(4);
    chk("R11 prep irq low", {31'b0, irqOut}, 0);
    @(negedge clk);
    pinIn[17] = 1'b0;
    idle(1);
    busWrite(6'h18, 32'h0002_0000, e);
    chk("R11 edge beats clear", {31'b0, irqOut}, 1);
    busWrite(6'h18, 32'h0002_0000, e);
    chk("R11 cleared afterwards", {31'b0, irqOut}, 0);

    idle(3);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1 pending reads actual=%0d expected=0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule